// File: doc/BRIEF.md
# USB Host Pipe Transaction Gate

This block sits inside a USB host controller, next to the pipe configuration and buffer logic. For every pipe, and in every frame, it decides whether the host may issue a token transaction on that pipe. When it may, it names the token kind: SETUP, IN or OUT. Each pipe is judged on its own, so choosing between several eligible pipes is left to a scheduler downstream.

Each pipe has these inputs:
- a transfer type;
- a direction;
- a handshake response mode;
- a setup-request flag;
- two buffer status bits.

A frame timer inside each pipe counts start-of-frame pulses, so that interrupt and isochronous pipes are only served in their scheduled frames. An isochronous pipe does not wait for its buffer. If it has no data to send, it sends a zero-length packet. If it has no receive space, it throws the incoming data away. The request pulse carries a flag for each of these two cases.

Top module: `usb_pipe_txn_gate`

## Requirements
- R1: No request is issued on any pipe unless both `host_mode_i` and `bus_active_i` are 1.
- R2: A pipe whose setup-request flag is set issues a SETUP request (token code 2). Type, direction, response mode, buffer state and frame validity are all ignored. SETUP takes priority over IN/OUT.
- R3: For control (type 0) and bulk (type 1) pipes, the frame timer is ignored and response mode must be BUF (code 1). An IN request (direction 0, token 1) additionally needs `rx_space_i`. An OUT request (direction 1, token 0) additionally needs `tx_data_i`.
- R4: An interrupt pipe (type 2) needs all three of the following: response mode BUF, a valid frame, and the buffer condition for its direction (as in R3).
- R5: An isochronous IN pipe (type 3) needs BUF and a valid frame, and nothing else. When it has no receive space, `drop_o` is 1 together with the request.
- R6: An isochronous OUT pipe needs BUF and a valid frame, and nothing else. When it has no transmit data, `zlp_o` is 1 together with the request.
- R7: The frame timer counts start-of-frame pulses:
  - It is 0 after reset.
  - On a `sof_i` pulse with the counter at 0, the frame is valid and the counter reloads with the pipe's interval value N.
  - On a `sof_i` pulse with the counter above 0, the counter decrements and the frame is not valid.
  - So the first frame after reset is valid, and after that one frame in every N+1 is valid.
- R8: An interrupt or isochronous pipe issues at most one IN/OUT request per valid frame.
- R9: `req_o` is a one-cycle pulse. Once a pipe has issued a request, it issues no new one until that pipe's `ack_i` has been seen.
- R10: With response mode NAK (0) or STALL (2, 3), no IN or OUT request is issued.
- R11: A `setup_set_i` pulse sets the pipe's setup-request flag, which is visible on `setup_pend_o`. The flag clears on the clock edge at which an outstanding SETUP request is acknowledged.
- R12: All outputs are 0 after reset. `req_o`, `tok_o`, `zlp_o` and `drop_o` are registered. They appear one clock after the conditions are present. A start-of-frame pulse affects requests two clocks after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_mode_i | input | 1 | Host mode selected |
| bus_active_i | input | 1 | Bus activity enabled |
| sof_i | input | 1 | Start-of-frame pulse, one clock wide |
| xfer_type_i | input | 2*NUM_PIPES | Transfer type per pipe: 0 control, 1 bulk, 2 interrupt, 3 isochronous |
| dir_out_i | input | NUM_PIPES | Direction per pipe: 1 OUT, 0 IN |
| rsp_i | input | 2*NUM_PIPES | Response mode per pipe: 0 NAK, 1 BUF, 2/3 STALL |
| interval_i | input | IVL_W*NUM_PIPES | Frame interval reload value per pipe |
| setup_set_i | input | NUM_PIPES | Pulse that sets the setup-request flag |
| rx_space_i | input | NUM_PIPES | Receive space available per pipe |
| tx_data_i | input | NUM_PIPES | Transmit data present per pipe |
| ack_i | input | NUM_PIPES | Acknowledge of the pipe's outstanding request |
| req_o | output | NUM_PIPES | Transaction request pulse per pipe |
| tok_o | output | 2*NUM_PIPES | Token kind per pipe: 0 OUT, 1 IN, 2 SETUP |
| zlp_o | output | NUM_PIPES | Send a zero-length packet (valid with `req_o`) |
| drop_o | output | NUM_PIPES | Discard received data (valid with `req_o`) |
| setup_pend_o | output | NUM_PIPES | Setup-request flag per pipe |

## Verification
There are three timing rules:
- A request, and its token kind and flags, are due one clock after the qualifying inputs are applied.
- A `sof_i` pulse reaches the request output two clocks after it is sampled.
- A setup flag responds one clock after its set pulse or its acknowledge.

The bench drives every input on the falling edge and reads the outputs on the falling edges that follow. In the sweep it raises the host enable for exactly one clock. As a result, the single falling-edge sample taken after that enable holds the whole decision for each combination of type, direction, response mode and buffer state.

For tests that span several frames, the bench counts request pulses over fixed windows between start-of-frame pulses. It does not rely on one exact cycle.

// File: rtl/usb_txgate_pkg.sv
package usb_txgate_pkg;

  typedef enum logic [1:0] {
    XF_CTRL = 2'd0,
    XF_BULK = 2'd1,
    XF_INTR = 2'd2,
    XF_ISO  = 2'd3
  } xfer_e;

  typedef enum logic [1:0] {
    TK_OUT   = 2'd0,
    TK_IN    = 2'd1,
    TK_SETUP = 2'd2,
    TK_NONE  = 2'd3
  } tok_e;

  localparam logic [1:0] RS_NAK = 2'd0;
  localparam logic [1:0] RS_BUF = 2'd1;

endpackage

// File: rtl/txg_frame_timer.sv
module txg_frame_timer #(
  parameter int IVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sof_i,
  input  logic [IVL_W-1:0] reload_i,
  input  logic             consume_i,
  output logic             frame_ok_o
);

  logic [IVL_W-1:0] cnt_q;
  logic             ok_q;

  // A frame is valid when the counter has reached zero at the start-of-frame
  // pulse. The open window is closed early once the pipe has used it.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (sof_i) begin
      if (cnt_q == '0) begin
        cnt_q <= reload_i;
        ok_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
        ok_q  <= 1'b0;
      end
    end else if (consume_i) begin
      ok_q <= 1'b0;
    end
  end

  assign frame_ok_o = ok_q;

endmodule

// File: rtl/txg_eligibility.sv
module txg_eligibility
  import usb_txgate_pkg::*;
(
  input  logic [1:0] xfer_i,
  input  logic       dir_out_i,
  input  logic [1:0] rsp_i,
  input  logic       setup_i,
  input  logic       rx_space_i,
  input  logic       tx_data_i,
  input  logic       frame_ok_i,
  output logic       fire_o,
  output tok_e       tok_o,
  output logic       zlp_o,
  output logic       drop_o,
  output logic       periodic_o
);

  logic  buf_ok;
  xfer_e kind;

  assign kind   = xfer_e'(xfer_i);
  assign buf_ok = dir_out_i ? tx_data_i : rx_space_i;

  always_comb begin
    fire_o     = 1'b0;
    tok_o      = TK_NONE;
    zlp_o      = 1'b0;
    drop_o     = 1'b0;
    periodic_o = 1'b0;
    if (setup_i) begin
      fire_o = 1'b1;
      tok_o  = TK_SETUP;
    end else if (rsp_i == RS_BUF) begin
      tok_o = dir_out_i ? TK_OUT : TK_IN;
      unique case (kind)
        XF_CTRL, XF_BULK: fire_o = buf_ok;
        XF_INTR: begin
          periodic_o = 1'b1;
          fire_o     = frame_ok_i & buf_ok;
        end
        XF_ISO: begin
          periodic_o = 1'b1;
          fire_o     = frame_ok_i;
          zlp_o      = dir_out_i & ~tx_data_i;
          drop_o     = ~dir_out_i & ~rx_space_i;
        end
        default: fire_o = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/txg_pipe.sv
module txg_pipe
  import usb_txgate_pkg::*;
#(
  parameter int IVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             sof_i,
  input  logic [1:0]       xfer_i,
  input  logic             dir_out_i,
  input  logic [1:0]       rsp_i,
  input  logic [IVL_W-1:0] interval_i,
  input  logic             setup_set_i,
  input  logic             rx_space_i,
  input  logic             tx_data_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [1:0]       tok_o,
  output logic             zlp_o,
  output logic             drop_o,
  output logic             setup_pend_o
);

  logic setup_q, pend_q, pend_setup_q;
  logic req_q, zlp_q, drop_q;
  logic [1:0] tok_q;
  logic frame_ok, fire, zlp_c, drop_c, periodic, issue;
  tok_e tok_c;

  txg_frame_timer #(.IVL_W(IVL_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .sof_i     (sof_i),
    .reload_i  (interval_i),
    .consume_i (issue & periodic),
    .frame_ok_o(frame_ok)
  );

  txg_eligibility u_elig (
    .xfer_i    (xfer_i),
    .dir_out_i (dir_out_i),
    .rsp_i     (rsp_i),
    .setup_i   (setup_q),
    .rx_space_i(rx_space_i),
    .tx_data_i (tx_data_i),
    .frame_ok_i(frame_ok),
    .fire_o    (fire),
    .tok_o     (tok_c),
    .zlp_o     (zlp_c),
    .drop_o    (drop_c),
    .periodic_o(periodic)
  );

  assign issue = run_i & ~pend_q & fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      setup_q      <= 1'b0;
      pend_q       <= 1'b0;
      pend_setup_q <= 1'b0;
      req_q        <= 1'b0;
      tok_q        <= 2'd0;
      zlp_q        <= 1'b0;
      drop_q       <= 1'b0;
    end else begin
      if (setup_set_i) setup_q <= 1'b1;
      else if (ack_i && pend_q && pend_setup_q) setup_q <= 1'b0;

      if (issue) begin
        pend_q       <= 1'b1;
        pend_setup_q <= (tok_c == TK_SETUP);
      end else if (ack_i) begin
        pend_q <= 1'b0;
      end

      req_q  <= issue;
      zlp_q  <= issue & zlp_c;
      drop_q <= issue & drop_c;
      if (issue) tok_q <= tok_c;
    end
  end

  assign req_o        = req_q;
  assign tok_o        = tok_q;
  assign zlp_o        = zlp_q;
  assign drop_o       = drop_q;
  assign setup_pend_o = setup_q;

endmodule

// File: rtl/usb_pipe_txn_gate.sv
module usb_pipe_txn_gate #(
  parameter int NUM_PIPES = 4,
  parameter int IVL_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       host_mode_i,
  input  logic                       bus_active_i,
  input  logic                       sof_i,
  input  logic [2*NUM_PIPES-1:0]     xfer_type_i,
  input  logic [NUM_PIPES-1:0]       dir_out_i,
  input  logic [2*NUM_PIPES-1:0]     rsp_i,
  input  logic [IVL_W*NUM_PIPES-1:0] interval_i,
  input  logic [NUM_PIPES-1:0]       setup_set_i,
  input  logic [NUM_PIPES-1:0]       rx_space_i,
  input  logic [NUM_PIPES-1:0]       tx_data_i,
  input  logic [NUM_PIPES-1:0]       ack_i,
  output logic [NUM_PIPES-1:0]       req_o,
  output logic [2*NUM_PIPES-1:0]     tok_o,
  output logic [NUM_PIPES-1:0]       zlp_o,
  output logic [NUM_PIPES-1:0]       drop_o,
  output logic [NUM_PIPES-1:0]       setup_pend_o
);

  logic run;
  assign run = host_mode_i & bus_active_i;

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    txg_pipe #(.IVL_W(IVL_W)) u_pipe (
      .clk         (clk),
      .rst         (rst),
      .run_i       (run),
      .sof_i       (sof_i),
      .xfer_i      (xfer_type_i[2*p +: 2]),
      .dir_out_i   (dir_out_i[p]),
      .rsp_i       (rsp_i[2*p +: 2]),
      .interval_i  (interval_i[IVL_W*p +: IVL_W]),
      .setup_set_i (setup_set_i[p]),
      .rx_space_i  (rx_space_i[p]),
      .tx_data_i   (tx_data_i[p]),
      .ack_i       (ack_i[p]),
      .req_o       (req_o[p]),
      .tok_o       (tok_o[2*p +: 2]),
      .zlp_o       (zlp_o[p]),
      .drop_o      (drop_o[p]),
      .setup_pend_o(setup_pend_o[p])
    );
  end

endmodule

// File: rtl/usb_pipe_txn_gate_chk.sv
module usb_pipe_txn_gate_chk #(
  parameter int NUM_PIPES = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   host_mode_i,
  input logic                   bus_active_i,
  input logic [2*NUM_PIPES-1:0] rsp_i,
  input logic [NUM_PIPES-1:0]   ack_i,
  input logic [NUM_PIPES-1:0]   req_o,
  input logic [2*NUM_PIPES-1:0] tok_o,
  input logic [NUM_PIPES-1:0]   zlp_o,
  input logic [NUM_PIPES-1:0]   drop_o,
  input logic [NUM_PIPES-1:0]   setup_pend_o
);

  logic [NUM_PIPES-1:0] outst_q;

  always_ff @(posedge clk) begin
    if (rst) outst_q <= '0;
    else     outst_q <= (req_o | outst_q) & ~ack_i;
  end

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_chk
    AST_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
      (!host_mode_i || !bus_active_i) |=> !req_o[p]);  // R1
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      req_o[p] |=> !req_o[p]);  // R9
    AST_NO_REQ_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
      (outst_q[p] && !ack_i[p]) |=> !req_o[p]);  // R9
    AST_ZLP_WITH_OUT: assert property (@(posedge clk) disable iff (rst)
      zlp_o[p] |-> (req_o[p] && tok_o[2*p +: 2] == 2'd0));  // R6
    AST_DROP_WITH_IN: assert property (@(posedge clk) disable iff (rst)
      drop_o[p] |-> (req_o[p] && tok_o[2*p +: 2] == 2'd1));  // R5
    AST_NONBUF_NO_DATA: assert property (@(posedge clk) disable iff (rst)
      (rsp_i[2*p +: 2] != 2'd1) |=> !(req_o[p] && tok_o[2*p +: 2] != 2'd2));  // R10
    AST_SETUP_CLEAR_ON_ACK: assert property (@(posedge clk) disable iff (rst)
      $fell(setup_pend_o[p]) |-> $past(ack_i[p]));  // R11
  end

endmodule

bind usb_pipe_txn_gate usb_pipe_txn_gate_chk #(.NUM_PIPES(NUM_PIPES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .host_mode_i (host_mode_i),
  .bus_active_i(bus_active_i),
  .rsp_i       (rsp_i),
  .ack_i       (ack_i),
  .req_o       (req_o),
  .tok_o       (tok_o),
  .zlp_o       (zlp_o),
  .drop_o      (drop_o),
  .setup_pend_o(setup_pend_o)
);

// File: tb/usb_pipe_txn_gate_bench.sv
`timescale 1ns/1ps
module usb_pipe_txn_gate_bench;

  localparam int NP = 4;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_mode_i = 1'b0, bus_active_i = 1'b1, sof_i = 1'b0;
  logic [2*NP-1:0]  xfer_type_i = '0;
  logic [NP-1:0]    dir_out_i = '0;
  logic [2*NP-1:0]  rsp_i = '0;
  logic [IW*NP-1:0] interval_i = '0;
  logic [NP-1:0]    setup_set_i = '0, rx_space_i = '0, tx_data_i = '0, ack_i = '0;
  logic [NP-1:0]    req_o, zlp_o, drop_o, setup_pend_o;
  logic [2*NP-1:0]  tok_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  usb_pipe_txn_gate #(.NUM_PIPES(NP), .IVL_W(IW)) u_usb_pipe_txn_gate (
    .clk(clk), .rst(rst), .host_mode_i(host_mode_i), .bus_active_i(bus_active_i),
    .sof_i(sof_i), .xfer_type_i(xfer_type_i), .dir_out_i(dir_out_i), .rsp_i(rsp_i),
    .interval_i(interval_i), .setup_set_i(setup_set_i), .rx_space_i(rx_space_i),
    .tx_data_i(tx_data_i), .ack_i(ack_i), .req_o(req_o), .tok_o(tok_o),
    .zlp_o(zlp_o), .drop_o(drop_o), .setup_pend_o(setup_pend_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; host_mode_i = 1'b0; sof_i = 1'b0; setup_set_i = '0; ack_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_pipe0(input int t, input int d, input int r, input int rx, input int tx);
    xfer_type_i[1:0] = 2'(t);
    dir_out_i[0]     = 1'(d);
    rsp_i[1:0]       = 2'(r);
    rx_space_i[0]    = 1'(rx);
    tx_data_i[0]     = 1'(tx);
  endtask

  // Count request and zero-length flags over windows between SOF pulses.
  task automatic frame_run(input string tag, input int t, input int d);
    int reqs, zlps;
    do_reset();
    interval_i[IW-1:0] = 4'd2;
    set_pipe0(t, d, 1, 1, 0);
    if (d == 0) rx_space_i[0] = 1'b1;
    host_mode_i = 1'b1; ack_i[0] = 1'b1;
    reqs = 0;
    repeat (3) begin @(negedge clk); reqs += int'(req_o[0]); end
    chk("R4", "requests before first valid frame", reqs, 0);
    for (int f = 0; f < 9; f++) begin
      sof_i = 1'b1;
      reqs = 0; zlps = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        sof_i = 1'b0;
        reqs += int'(req_o[0]);
        zlps += int'(zlp_o[0]);
      end
      chk(tag, $sformatf("requests in frame %0d", f), reqs, (f % 3 == 0) ? 1 : 0);
      if (d == 1) chk("R6", $sformatf("zlp in frame %0d", f), zlps, (f % 3 == 0) ? 1 : 0);
    end
    host_mode_i = 1'b0; ack_i[0] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    do_reset();
    @(negedge clk);
    chk("R12", "req after reset", int'(req_o), 0);
    chk("R12", "setup_pend after reset", int'(setup_pend_o), 0);
    chk("R12", "zlp/drop after reset", int'(zlp_o | drop_o), 0);

    // Sweep of type x direction x response x buffer state on pipe 0.
    ack_i[0] = 1'b1;
    for (int t = 0; t < 4; t++)
      for (int d = 0; d < 2; d++)
        for (int r = 0; r < 4; r++)
          for (int rx = 0; rx < 2; rx++)
            for (int tx = 0; tx < 2; tx++) begin
              int bufok, er, ez, ed;
              string tag;
              @(negedge clk);
              host_mode_i = 1'b0;
              set_pipe0(t, d, r, rx, tx);
              interval_i[IW-1:0] = '0;
              sof_i = 1'b1;
              @(negedge clk);
              sof_i = 1'b0; host_mode_i = 1'b1;
              @(negedge clk);
              host_mode_i = 1'b0;
              bufok = (d == 1) ? tx : rx;
              er = (r != 1) ? 0 : ((t == 3) ? 1 : bufok);
              ez = (er == 1 && t == 3 && d == 1 && tx == 0) ? 1 : 0;
              ed = (er == 1 && t == 3 && d == 0 && rx == 0) ? 1 : 0;
              if (r != 1) tag = "R10";
              else if (t < 2) tag = "R3";
              else if (t == 2) tag = "R4";
              else if (d == 1) tag = "R6";
              else tag = "R5";
              chk(tag, $sformatf("req t%0d d%0d r%0d rx%0d tx%0d", t, d, r, rx, tx), int'(req_o[0]), er);
              if (er == 1) chk(tag, "token", int'(tok_o[1:0]), (d == 1) ? 0 : 1);
              chk(tag, "zlp", int'(zlp_o[0]), ez);
              chk(tag, "drop", int'(drop_o[0]), ed);
            end
    ack_i[0] = 1'b0;

    // Bus enable low blocks an eligible bulk pipe.
    do_reset();
    set_pipe0(1, 1, 1, 0, 1);
    host_mode_i = 1'b1; bus_active_i = 1'b0;
    cnt = 0;
    repeat (4) begin @(negedge clk); cnt += int'(req_o[0]); end
    chk("R1", "requests with bus inactive", cnt, 0);
    bus_active_i = 1'b1;

    // Outstanding request holds off further ones until ack.
    @(negedge clk);
    chk("R12", "request one clock after enable", int'(req_o[0]), 1);
    cnt = 0;
    repeat (8) begin @(negedge clk); cnt += int'(req_o[0]); end
    chk("R9", "requests while unacknowledged", cnt, 0);
    ack_i[0] = 1'b1;
    @(negedge clk);
    ack_i[0] = 1'b0;
    cnt = 0;
    repeat (4) begin @(negedge clk); cnt += int'(req_o[0]); end
    chk("R9", "requests after one ack", cnt, 1);
    host_mode_i = 1'b0;

    // Setup request: priority, gating, clear on ack.
    do_reset();
    set_pipe0(3, 0, 0, 0, 0);
    setup_set_i[0] = 1'b1;
    @(negedge clk);
    setup_set_i[0] = 1'b0;
    chk("R11", "setup flag after set pulse", int'(setup_pend_o[0]), 1);
    cnt = 0;
    repeat (2) begin @(negedge clk); cnt += int'(req_o[0]); end
    chk("R1", "setup requests with host mode off", cnt, 0);
    host_mode_i = 1'b1;
    @(negedge clk);
    chk("R2", "setup request issued", int'(req_o[0]), 1);
    chk("R2", "setup token", int'(tok_o[1:0]), 2);
    cnt = 0;
    repeat (3) begin @(negedge clk); cnt += int'(req_o[0]); end
    chk("R9", "setup re-requests before ack", cnt, 0);
    chk("R11", "setup flag held before ack", int'(setup_pend_o[0]), 1);
    ack_i[0] = 1'b1;
    @(negedge clk);
    ack_i[0] = 1'b0;
    chk("R11", "setup flag cleared by ack", int'(setup_pend_o[0]), 0);
    cnt = 0;
    repeat (3) begin @(negedge clk); cnt += int'(req_o[0]); end
    chk("R10", "requests after setup with NAK", cnt, 0);
    host_mode_i = 1'b0;

    // Frame timer with interval 2 on interrupt IN and isochronous OUT.
    frame_run("R7", 2, 0);
    frame_run("R8", 3, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule